// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block links two processors, called side A and side B, through a pair of identical register ports. Each side owns four 32-bit outgoing message slots. A word that one side writes into outgoing slot n lands in incoming slot n of the other side. A full/empty handshake for each slot tells both sides whether the word has been consumed. Beside the message slots, each side can publish a 3-bit flag value that the peer sees in its status word. Each side can also raise four doorbell interrupts on the peer. A doorbell cannot be raised again until the peer has acknowledged it.

Each side has one level interrupt output, formed from its status bits and its enable bits. Either side can start a mailbox reset. The reset wipes the message handshakes, the doorbells and the flags on both sides for a fixed number of cycles.

The register port of each side has a 3-bit word address. Addresses 0..3 are the message slots: a write goes to outgoing slot n and a read returns incoming slot n. Address 4 is the status word and address 5 is the control word. A read returns its data one cycle after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: A write to address n (0..3) on one side stores the word for the peer. At the next clock edge the peer's receive-full bit n is 1 and the writer's transmit-empty bit n is 0. A later read of address n on the peer returns that word.
- R2: A read of address n clears the reader's receive-full bit n and sets the writer's transmit-empty bit n at the next edge.
- R3: The four channels are independent: traffic on one channel changes no status bit of another channel.
- R4: Status word layout: transmit-empty n at bit 31-n, receive-full n at bit 27-n, doorbell-pending n at bit 23-n, event-pending at bit 19, flags-updating at bit 18, mailbox-in-reset at bit 17, peer flags at bits 2:0. Control word layout: transmit-empty enable n at bit 31-n, receive-full enable n at bit 27-n, doorbell enable n at bit 23-n, doorbell request n at bit 19-n, mailbox reset at bit 15, own flags at bits 2:0.
- R5: Writes to the status word leave the transmit-empty, receive-full, event-pending, flags-updating and in-reset bits unchanged.
- R6: Doorbell-pending bits are write-1-to-clear through the status word. Writing 0 leaves them set.
- R7: Writing 1 to request bit n sets the peer's pending bit n. The request bit reads 1 until the peer clears that pending bit, then reads 0 with no further action. A request made while the peer's pending bit is still set is dropped, and writing 0 to a request bit has no effect.
- R8: A control write with a new flag value sets flags-updating for two cycles. The value reaches the peer's status word when the update completes. Flag changes written while flags-updating is 1 are refused.
- R9: The interrupt output is 1 one cycle after any transmit-empty, receive-full or doorbell-pending bit is 1 together with its enable, and 0 otherwise.
- R10: Event-pending is 1 exactly when any receive-full or doorbell-pending bit of that side is 1.
- R11: Writing 1 to the mailbox-reset bit on either side holds the in-reset bit high on both sides for four cycles. The reset empties all channels, clears all pending bits and zeroes all flags, and message writes made during it are lost.
- R12: After the system reset each status word reads 0xF000_0000, each control word reads 0 and both interrupt outputs are 0.
- R13: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 3 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 3 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions assume that a strobe never targets an address above 5 and that no single cycle carries both a write and a read on one side. The directed tasks keep to this: each bus task drives exactly one strobe for one cycle at a legal address. The timing checks on flags and doorbells assume that back-to-back accesses land on consecutive clock edges. The bench keeps this true by starting and ending every access on a falling edge, with no idle cycle between accesses.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned MBOX_NCH_DEF = 4;
  localparam int unsigned MBOX_DW_DEF  = 32;
  localparam int unsigned MBOX_FW_DEF  = 3;
  localparam int unsigned MBOX_AW_DEF  = 3;

  typedef enum logic [1:0] {
    RK_MSG  = 2'd0,
    RK_STAT = 2'd1,
    RK_CTRL = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/mbox_lane.sv
module mbox_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (wr) data <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  full <= 1'b0;
    else if (wr)     full <= 1'b1;
    else if (rd)     full <= 1'b0;
  end

  assert_fill_R1: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> full);
  assert_drain_R2: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && !clr) |=> !full);
  assert_wipe_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> !full);
endmodule

// File: rtl/mbox_flag_link.sv
module mbox_flag_link #(
  parameter int unsigned FW  = 3,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [FW-1:0] val,
  output logic [FW-1:0] own,
  output logic [FW-1:0] peer,
  output logic          busy
);
  localparam int unsigned CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = wr && !busy && (val != own);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      own  <= '0;
      peer <= '0;
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      own  <= val;
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        peer <= own;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assert_refuse_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr) |=> $stable(own));
  assert_mirror_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr) |=> $stable(peer));
  assert_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !clr) |=> busy);
endmodule

// File: rtl/mbox_gp_link.sv
module mbox_gp_link #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [NCH-1:0] raise,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst || clr) pend <= '0;
    else            pend <= (pend & ~ack) | (raise & ~pend);
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_raise_R7: assert property (@(posedge clk) disable iff (rst)
      (raise[n] && !pend[n] && !clr) |=> pend[n]);
    assert_no_rearm_R7: assert property (@(posedge clk) disable iff (rst)
      (pend[n] && ack[n] && !clr) |=> !pend[n]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (pend[n] && !ack[n] && !clr) |=> pend[n]);
  end
endmodule

// File: rtl/mbox_side.sv
module mbox_side
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned FW  = 3,
  parameter int unsigned AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    irq,
  input  logic [NCH-1:0][DW-1:0]  rx_data,
  input  logic [NCH-1:0]          rx_full,
  input  logic [NCH-1:0]          tx_empty,
  input  logic [NCH-1:0]          gp_pend,
  input  logic [NCH-1:0]          gp_req,
  input  logic [FW-1:0]           own_flags,
  input  logic [FW-1:0]           peer_flags,
  input  logic                    flag_busy,
  input  logic                    in_reset,
  output logic [NCH-1:0]          tx_wr,
  output logic [NCH-1:0]          rx_rd,
  output logic [NCH-1:0]          gp_clr,
  output logic [NCH-1:0]          gp_raise,
  output logic                    flag_wr,
  output logic [FW-1:0]           flag_val,
  output logic                    mreset_req
);
  localparam int unsigned IW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned G_TE  = DW - 1;
  localparam int unsigned G_RF  = DW - 1 - NCH;
  localparam int unsigned G_GP  = DW - 1 - 2 * NCH;
  localparam int unsigned G_RQ  = DW - 1 - 3 * NCH;
  localparam int unsigned B_MR  = DW - 1 - 4 * NCH;
  localparam int unsigned PAD_S = DW - 3 * NCH - 3 - FW;
  localparam int unsigned PAD_C = DW - 4 * NCH - 1 - FW;

  reg_kind_e      kind;
  logic [NCH-1:0] te_en, rf_en, gp_en;
  logic [NCH-1:0] te_en_d, rf_en_d, gp_en_d;
  logic [NCH-1:0] te_rev, rf_rev, gp_rev, ten_rev, ren_rev, gen_rev, req_rev;
  logic [DW-1:0]  st_word, ct_word;
  logic           ev_pend;
  logic           unused_wbits;

  always_comb begin
    if (addr < AW'(NCH))           kind = RK_MSG;
    else if (addr == AW'(NCH))     kind = RK_STAT;
    else if (addr == AW'(NCH + 1)) kind = RK_CTRL;
    else                           kind = RK_NONE;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign tx_wr[n]    = wr && (kind == RK_MSG) && (addr == AW'(n));
    assign rx_rd[n]    = rd && (kind == RK_MSG) && (addr == AW'(n));
    assign gp_clr[n]   = wr && (kind == RK_STAT) && wdata[G_GP - n];
    assign gp_raise[n] = wr && (kind == RK_CTRL) && wdata[G_RQ - n];
    assign te_en_d[n]  = wdata[G_TE - n];
    assign rf_en_d[n]  = wdata[G_RF - n];
    assign gp_en_d[n]  = wdata[G_GP - n];
    assign te_rev[NCH-1-n]  = tx_empty[n];
    assign rf_rev[NCH-1-n]  = rx_full[n];
    assign gp_rev[NCH-1-n]  = gp_pend[n];
    assign ten_rev[NCH-1-n] = te_en[n];
    assign ren_rev[NCH-1-n] = rf_en[n];
    assign gen_rev[NCH-1-n] = gp_en[n];
    assign req_rev[NCH-1-n] = gp_req[n];
  end

  assign flag_wr      = wr && (kind == RK_CTRL);
  assign flag_val     = wdata[FW-1:0];
  assign mreset_req   = wr && (kind == RK_CTRL) && wdata[B_MR];
  assign unused_wbits = ^wdata;

  assign ev_pend = (|rx_full) || (|gp_pend);
  assign st_word = {te_rev, rf_rev, gp_rev, ev_pend, flag_busy, in_reset,
                    {PAD_S{1'b0}}, peer_flags};
  assign ct_word = {ten_rev, ren_rev, gen_rev, req_rev, in_reset,
                    {PAD_C{1'b0}}, own_flags};

  always_ff @(posedge clk) begin
    if (rst) begin
      te_en <= '0;
      rf_en <= '0;
      gp_en <= '0;
    end else if (wr && kind == RK_CTRL) begin
      te_en <= te_en_d;
      rf_en <= rf_en_d;
      gp_en <= gp_en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (|(tx_empty & te_en)) || (|(rx_full & rf_en)) || (|(gp_pend & gp_en));
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) begin
      case (kind)
        RK_MSG:  rdata <= rx_data[addr[IW-1:0]];
        RK_STAT: rdata <= st_word;
        RK_CTRL: rdata <= ct_word;
        default: rdata <= '0;
      endcase
    end
  end

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (te_en == '0 && rf_en == '0 && gp_en == '0) |=> !irq);
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  assert_ev_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_full == '0 && gp_pend == '0) |-> !st_word[G_RQ]);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned FW       = 3,
  parameter int unsigned AW       = 3,
  parameter int unsigned FLAG_LAT = 2,
  parameter int unsigned RST_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int unsigned RW = $clog2(RST_CYC + 1);

  logic [NCH-1:0][DW-1:0] ab_data, ba_data;
  logic [NCH-1:0]         ab_full, ba_full;
  logic [NCH-1:0]         a_tx_wr, a_rx_rd, a_gp_clr, a_gp_raise;
  logic [NCH-1:0]         b_tx_wr, b_rx_rd, b_gp_clr, b_gp_raise;
  logic [NCH-1:0]         gp_ab_pend, gp_ba_pend;
  logic [FW-1:0]          a_flag_val, b_flag_val;
  logic [FW-1:0]          fl_ab_own, fl_ab_peer, fl_ba_own, fl_ba_peer;
  logic                   a_flag_wr, b_flag_wr, fl_ab_busy, fl_ba_busy;
  logic                   a_mr, b_mr, in_reset;
  logic [RW-1:0]          rst_cnt;

  always_ff @(posedge clk) begin
    if (rst)                rst_cnt <= '0;
    else if (a_mr || b_mr)  rst_cnt <= RW'(RST_CYC);
    else if (rst_cnt != '0) rst_cnt <= rst_cnt - RW'(1);
  end
  assign in_reset = (rst_cnt != '0);

  for (genvar n = 0; n < NCH; n++) begin : g_lane
    mbox_lane #(.DW(DW)) u_ab (
      .clk(clk), .rst(rst), .clr(in_reset), .wr(a_tx_wr[n]), .wdata(a_wdata),
      .rd(b_rx_rd[n]), .data(ab_data[n]), .full(ab_full[n]));
    mbox_lane #(.DW(DW)) u_ba (
      .clk(clk), .rst(rst), .clr(in_reset), .wr(b_tx_wr[n]), .wdata(b_wdata),
      .rd(a_rx_rd[n]), .data(ba_data[n]), .full(ba_full[n]));
  end

  mbox_gp_link #(.NCH(NCH)) u_gp_ab (
    .clk(clk), .rst(rst), .clr(in_reset), .raise(a_gp_raise), .ack(b_gp_clr),
    .pend(gp_ab_pend));
  mbox_gp_link #(.NCH(NCH)) u_gp_ba (
    .clk(clk), .rst(rst), .clr(in_reset), .raise(b_gp_raise), .ack(a_gp_clr),
    .pend(gp_ba_pend));

  mbox_flag_link #(.FW(FW), .LAT(FLAG_LAT)) u_fl_ab (
    .clk(clk), .rst(rst), .clr(in_reset), .wr(a_flag_wr), .val(a_flag_val),
    .own(fl_ab_own), .peer(fl_ab_peer), .busy(fl_ab_busy));
  mbox_flag_link #(.FW(FW), .LAT(FLAG_LAT)) u_fl_ba (
    .clk(clk), .rst(rst), .clr(in_reset), .wr(b_flag_wr), .val(b_flag_val),
    .own(fl_ba_own), .peer(fl_ba_peer), .busy(fl_ba_busy));

  mbox_side #(.NCH(NCH), .DW(DW), .FW(FW), .AW(AW)) u_side_a (
    .clk(clk), .rst(rst), .wr(a_wr), .rd(a_rd), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq), .rx_data(ba_data), .rx_full(ba_full),
    .tx_empty(~ab_full), .gp_pend(gp_ba_pend), .gp_req(gp_ab_pend),
    .own_flags(fl_ab_own), .peer_flags(fl_ba_peer), .flag_busy(fl_ab_busy),
    .in_reset(in_reset), .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .gp_clr(a_gp_clr),
    .gp_raise(a_gp_raise), .flag_wr(a_flag_wr), .flag_val(a_flag_val),
    .mreset_req(a_mr));

  mbox_side #(.NCH(NCH), .DW(DW), .FW(FW), .AW(AW)) u_side_b (
    .clk(clk), .rst(rst), .wr(b_wr), .rd(b_rd), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq), .rx_data(ab_data), .rx_full(ab_full),
    .tx_empty(~ba_full), .gp_pend(gp_ab_pend), .gp_req(gp_ba_pend),
    .own_flags(fl_ba_own), .peer_flags(fl_ab_peer), .flag_busy(fl_ba_busy),
    .in_reset(in_reset), .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .gp_clr(b_gp_clr),
    .gp_raise(b_gp_raise), .flag_wr(b_flag_wr), .flag_val(b_flag_val),
    .mreset_req(b_mr));

  assert_mr_start_R11: assert property (@(posedge clk) disable iff (rst)
    (a_mr || b_mr) |=> in_reset);
  assert_mr_empty_R11: assert property (@(posedge clk) disable iff (rst)
    in_reset |=> (ab_full == '0 && ba_full == '0 && gp_ab_pend == '0 && gp_ba_pend == '0));
  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    !(a_wr && a_rd) && !(b_wr && b_rd));
endmodule

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [2:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;
  logic [31:0] v;

  localparam logic [2:0] ST = 3'd4, CT = 3'd5;

  always #2.5 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit side_b, input logic [2:0] ad, input logic [31:0] d);
    if (side_b) begin b_wr = 1'b1; b_addr = ad; b_wdata = d; end
    else        begin a_wr = 1'b1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic rd_reg(input bit side_b, input logic [2:0] ad, output logic [31:0] d);
    if (side_b) begin b_rd = 1'b1; b_addr = ad; end
    else        begin a_rd = 1'b1; a_addr = ad; end
    @(negedge clk);
    d = side_b ? b_rdata : a_rdata;
    a_rd = 1'b0; b_rd = 1'b0;
  endtask

  task automatic t_reset;
    rd_reg(0, ST, v); chk("R12 A status", v, 32'hF000_0000);
    rd_reg(1, ST, v); chk("R12 B status", v, 32'hF000_0000);
    rd_reg(0, CT, v); chk("R12 A control", v, 32'h0);
    chk("R12 irqs", {30'd0, a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_message;
    wr_reg(0, 3'd0, 32'hDEAD_BEEF);
    rd_reg(1, ST, v); chk("R1 R10 B status after fill", v, 32'hF808_0000);
    rd_reg(0, ST, v); chk("R1 A tx-empty cleared", v, 32'h7000_0000);
    rd_reg(1, 3'd0, v); chk("R1 R13 B receive data", v, 32'hDEAD_BEEF);
    chk("R13 data held", b_rdata, 32'hDEAD_BEEF);
    rd_reg(1, ST, v); chk("R2 R10 B status after read", v, 32'hF000_0000);
    rd_reg(0, ST, v); chk("R2 A tx-empty restored", v, 32'hF000_0000);
  endtask

  task automatic t_parallel;
    wr_reg(1, 3'd3, 32'h0000_0033);
    wr_reg(1, 3'd1, 32'h0000_0011);
    rd_reg(0, ST, v); chk("R3 R4 A status two channels", v, 32'hF508_0000);
    rd_reg(1, ST, v); chk("R3 R4 B tx-empty pattern", v, 32'hA000_0000);
    rd_reg(0, 3'd3, v); chk("R3 channel 3 data", v, 32'h0000_0033);
    rd_reg(0, ST, v); chk("R3 channel 1 still full", v, 32'hF408_0000);
    rd_reg(0, 3'd1, v); chk("R3 channel 1 data", v, 32'h0000_0011);
  endtask

  task automatic t_hwbits;
    wr_reg(1, 3'd2, 32'h0000_0022);
    wr_reg(0, ST, 32'hFFFF_FFFF);
    rd_reg(0, ST, v); chk("R5 status write ignored", v, 32'hF208_0000);
    rd_reg(0, 3'd2, v); chk("R5 message intact", v, 32'h0000_0022);
  endtask

  task automatic t_doorbell;
    wr_reg(0, CT, 32'h0004_0000);
    rd_reg(1, ST, v); chk("R7 R10 B pending 1", v, 32'hF048_0000);
    rd_reg(0, CT, v); chk("R7 A request reads 1", v, 32'h0004_0000);
    wr_reg(0, CT, 32'h0004_0000);
    wr_reg(1, ST, 32'h0000_0000);
    rd_reg(1, ST, v); chk("R6 write 0 keeps pending", v, 32'hF048_0000);
    wr_reg(1, ST, 32'h0040_0000);
    rd_reg(1, ST, v); chk("R6 R7 cleared, no re-raise", v, 32'hF000_0000);
    rd_reg(0, CT, v); chk("R7 request self-cleared", v, 32'h0);
    wr_reg(0, CT, 32'h0);
    rd_reg(1, ST, v); chk("R7 write 0 no request", v, 32'hF000_0000);
  endtask

  task automatic t_irq;
    wr_reg(1, CT, 32'h0800_0000);
    repeat (2) @(negedge clk);
    chk("R9 rx enable only, no event", {31'd0, b_irq}, 32'd0);
    wr_reg(0, 3'd0, 32'h0000_0005);
    repeat (2) @(negedge clk);
    chk("R9 rx-full irq", {31'd0, b_irq}, 32'd1);
    rd_reg(1, 3'd0, v);
    repeat (2) @(negedge clk);
    chk("R9 irq drops after read", {31'd0, b_irq}, 32'd0);
    wr_reg(1, CT, 32'h8000_0000);
    repeat (2) @(negedge clk);
    chk("R9 tx-empty irq", {31'd0, b_irq}, 32'd1);
    wr_reg(1, CT, 32'h0020_0000);
    repeat (2) @(negedge clk);
    chk("R9 doorbell enable idle", {31'd0, b_irq}, 32'd0);
    wr_reg(0, CT, 32'h0002_0000);
    repeat (2) @(negedge clk);
    chk("R9 doorbell irq", {31'd0, b_irq}, 32'd1);
    wr_reg(1, ST, 32'h0020_0000);
    repeat (2) @(negedge clk);
    chk("R9 doorbell acked", {31'd0, b_irq}, 32'd0);
    wr_reg(1, CT, 32'h0);
  endtask

  task automatic t_flags;
    wr_reg(0, CT, 32'h0000_0005);
    rd_reg(0, ST, v); chk("R8 busy during update", v, 32'hF004_0000);
    wr_reg(0, CT, 32'h0000_0002);
    repeat (4) @(negedge clk);
    rd_reg(1, ST, v); chk("R8 peer sees flags", v, 32'hF000_0005);
    rd_reg(0, CT, v); chk("R8 change refused while busy", v, 32'h0000_0005);
    rd_reg(0, ST, v); chk("R8 busy cleared", v, 32'hF000_0000);
    wr_reg(0, CT, 32'h0000_0002);
    repeat (4) @(negedge clk);
    rd_reg(1, ST, v); chk("R8 second update", v, 32'hF000_0002);
  endtask

  task automatic t_mreset;
    wr_reg(0, 3'd1, 32'h0000_0077);
    wr_reg(1, CT, 32'h0008_0000);
    wr_reg(1, CT, 32'h0000_8000);
    rd_reg(0, ST, v); chk("R11 in-reset bit", v & 32'h0002_0000, 32'h0002_0000);
    wr_reg(0, 3'd2, 32'h0000_0099);
    repeat (8) @(negedge clk);
    rd_reg(0, ST, v); chk("R11 A cleared", v, 32'hF000_0000);
    rd_reg(1, ST, v); chk("R11 B cleared, write lost", v, 32'hF000_0000);
    rd_reg(0, CT, v); chk("R11 A flags zero", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_message();
    t_parallel();
    t_hwbits();
    t_doorbell();
    t_irq();
    t_flags();
    t_mreset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule